// File: doc/BRIEF.md
# Single-Cycle Clock Glitch Margining Generator

The block derives a test clock from a fast reference clock. An unaltered output cycle is a fixed number of reference ticks high followed by the same number low. Once a run is started, the block makes one output cycle in every `GLITCH_EVERY` different from the rest. In shrink mode that cycle is shortened. In stretch mode it is lengthened. The amount grows in equal steps of `STEP_TICKS` ticks per level, and with the defaults one step is 10 percent of the 20-tick nominal period.

A level is held for `EVENTS_PER_LEVEL` altered cycles. If the anomaly input stays low for all of them, the block moves up one level. Level 5 (50 percent) is the last. When it completes with no anomaly the run is done and the clock goes back to nominal cycles only. If the anomaly input is raised while a run is going, the block stops altering cycles and keeps the level code (1 to 5) on its status output, so the failing margin can be read off.

The controller has four states. IDLE is entered from reset. RUN is entered by the transition *launch*, which is `start` taken in IDLE, HIT or DONE. HIT is entered from RUN by the transition *trip*, which is `anomaly` taken in RUN. DONE is entered from RUN by the transition *exhaust*, which happens when the last altered cycle of the top level ends. Within RUN the transition *advance* raises the level by one and stays in RUN.

Top module: `glitch_margin_gen`

## Requirements
- R1: During and right after reset, `gclk` is 1, `level` is 0, and `hit` and `done` are 0.
- R2: Every unaltered output cycle is `HALF_TICKS` (default 10) reference ticks high, then `HALF_TICKS` ticks low, which gives a 50 percent duty cycle.
- R3: *launch* sets `level` to 1 and restarts the cycle count. The cycle in progress at *launch* counts as cycle 0. While in RUN, the cycle that begins at the `GLITCH_EVERY-1`th cycle boundary after the count was last cleared is altered, and the count then wraps. Altered cycles are therefore exactly `GLITCH_EVERY` cycles apart.
- R4: In shrink mode (`stretch_mode`=0), an altered cycle at level L is `STEP_TICKS*L` ticks shorter than nominal. The cut is taken from the low phase first, and the low phase is never shorter than 1 tick. Any remaining cut comes off the high phase, so at level 5 with the defaults the cycle is 9 ticks high and 1 tick low. No high phase is ever longer than `HALF_TICKS`.
- R5: *advance*: after `EVENTS_PER_LEVEL` altered cycles at one level with no anomaly, `level` rises by exactly 1. Apart from *launch*, `level` never changes by any other amount.
- R6: *exhaust*: when the last altered cycle of level `MAX_LEVEL` ends with no anomaly, `done` goes to 1, `level` stays at `MAX_LEVEL`, and every later cycle is nominal.
- R7: *trip*: `anomaly` in RUN sets `hit` to 1 on the next edge and freezes `level`. An altered cycle already under way finishes with its lengths, and no new cycle is altered.
- R8: In stretch mode (`stretch_mode`=1, sampled at the start of each cycle), an altered cycle at level L keeps a `HALF_TICKS` high phase, and its low phase is `HALF_TICKS+STEP_TICKS*L` ticks long.
- R9: `start` while in RUN has no effect. `start` in HIT or DONE clears `hit` or `done` and begins a new run at level 1.
- R10: `anomaly` outside RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a margining run (taken outside RUN) |
| anomaly | input | 1 | Target misbehaviour seen; stops the run |
| stretch_mode | input | 1 | 0: shorten the altered cycle, 1: lengthen it |
| gclk | output | 1 | Generated test clock |
| level | output | $clog2(MAX_LEVEL+1) | Current margin level code, 0 when idle |
| hit | output | 1 | Run stopped by an anomaly |
| done | output | 1 | All levels completed with no anomaly |

## Verification
A wrong count in the tick, cycle or event counters shows up as an output phase that is one tick off. When it affects an altered cycle, that mistake is visible on `gclk` within one output period. When it misplaces the altered cycle itself, it is visible within `GLITCH_EVERY` periods. A wrong controller state shows on `level`, `hit` or `done` on the edge after the stimulus that exposes it, and it also shows on `gclk` once the next altered cycle is due. The reference model follows every tick, so each of these shows as a mismatch in the cycle where it first reaches a port.

// File: rtl/gm_pkg.sv
package gm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HIT  = 2'd2,
        ST_DONE = 2'd3
    } gm_state_t;
endpackage

// File: rtl/gm_phase_gen.sv
// Tick counter producing the output clock; lengths are latched per cycle.
module gm_phase_gen #(
    parameter int HALF_TICKS = 10,
    parameter int CW         = 6
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic [CW-1:0] nxt_hi,
    input  logic [CW-1:0] nxt_lo,
    output logic          gclk,
    output logic          cyc_end
);
    logic          phase_q;
    logic [CW-1:0] tcnt_q;
    logic [CW-1:0] hi_q;
    logic [CW-1:0] lo_q;
    logic          hi_end;

    assign hi_end  = phase_q && (tcnt_q == hi_q - CW'(1));
    assign cyc_end = !phase_q && (tcnt_q == lo_q - CW'(1));
    assign gclk    = phase_q;

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
            tcnt_q  <= '0;
            hi_q    <= CW'(HALF_TICKS);
            lo_q    <= CW'(HALF_TICKS);
        end else if (cyc_end) begin
            phase_q <= 1'b1;
            tcnt_q  <= '0;
            hi_q    <= nxt_hi;
            lo_q    <= nxt_lo;
        end else if (hi_end) begin
            phase_q <= 1'b0;
            tcnt_q  <= '0;
        end else begin
            tcnt_q  <= tcnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/gm_cycle_sched.sv
// Counts output cycles and marks every GLITCH_EVERY-th one for alteration.
module gm_cycle_sched #(
    parameter int GLITCH_EVERY = 1000
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic restart,
    input  logic cyc_end,
    input  logic run_next,
    output logic alt_next,
    output logic cur_alt
);
    localparam int NW = $clog2(GLITCH_EVERY);

    logic [NW-1:0] cyc_q;
    logic [NW-1:0] cyc_inc;

    assign cyc_inc  = (cyc_q == NW'(GLITCH_EVERY - 1)) ? '0 : cyc_q + NW'(1);
    assign alt_next = run_next && !restart && (cyc_inc == NW'(GLITCH_EVERY - 1));

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            cur_alt <= 1'b0;
        end else begin
            if (restart)      cyc_q <= '0;
            else if (cyc_end) cyc_q <= cyc_inc;
            if (cyc_end)      cur_alt <= alt_next;
        end
    end
endmodule

// File: rtl/gm_level_fsm.sv
// Run controller: launch / trip / advance / exhaust.
module gm_level_fsm
    import gm_pkg::*;
#(
    parameter int MAX_LEVEL        = 5,
    parameter int EVENTS_PER_LEVEL = 4,
    parameter int LW               = 3
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          start,
    input  logic          anomaly,
    input  logic          alt_done,
    output gm_state_t     state_nx,
    output logic          restart,
    output logic [LW-1:0] level,
    output logic          hit,
    output logic          done
);
    localparam int EW = $clog2(EVENTS_PER_LEVEL) + 1;

    gm_state_t     state_q;
    logic [EW-1:0] ev_q;
    logic          last_ev;
    logic          top_lvl;

    assign last_ev = (ev_q == EW'(EVENTS_PER_LEVEL - 1));
    assign top_lvl = (level == LW'(MAX_LEVEL));
    assign restart = start && (state_q != ST_RUN);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_DONE: if (start) state_nx = ST_RUN;
            ST_RUN: begin
                if (anomaly)                              state_nx = ST_HIT;
                else if (alt_done && last_ev && top_lvl)  state_nx = ST_DONE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_ref) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            level <= '0;
            ev_q  <= '0;
        end else if (restart) begin
            level <= LW'(1);
            ev_q  <= '0;
        end else if (state_q == ST_RUN && !anomaly && alt_done) begin
            if (last_ev) begin
                ev_q <= '0;
                if (!top_lvl) level <= level + LW'(1);
            end else begin
                ev_q <= ev_q + EW'(1);
            end
        end
    end

    always_comb begin
        hit  = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_HIT:  hit  = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/glitch_margin_gen.sv
module glitch_margin_gen
    import gm_pkg::*;
#(
    parameter int HALF_TICKS       = 10,
    parameter int STEP_TICKS       = 2,
    parameter int MAX_LEVEL        = 5,
    parameter int GLITCH_EVERY     = 1000,
    parameter int EVENTS_PER_LEVEL = 4,
    localparam int LW = $clog2(MAX_LEVEL + 1)
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          start,
    input  logic          anomaly,
    input  logic          stretch_mode,
    output logic          gclk,
    output logic [LW-1:0] level,
    output logic          hit,
    output logic          done
);
    localparam int CW = $clog2(HALF_TICKS + STEP_TICKS * MAX_LEVEL + 1) + 1;

    gm_state_t     state_nx;
    logic          restart;
    logic          cyc_end;
    logic          alt_next;
    logic          cur_alt;
    logic [CW-1:0] delta;
    logic [CW-1:0] lo_cut;
    logic [CW-1:0] nxt_hi;
    logic [CW-1:0] nxt_lo;

    assign delta  = CW'(STEP_TICKS) * CW'(level);
    assign lo_cut = (delta > CW'(HALF_TICKS - 1)) ? CW'(HALF_TICKS - 1) : delta;

    always_comb begin
        nxt_hi = CW'(HALF_TICKS);
        nxt_lo = CW'(HALF_TICKS);
        if (alt_next) begin
            if (stretch_mode) begin
                nxt_lo = CW'(HALF_TICKS) + delta;
            end else begin
                nxt_lo = CW'(HALF_TICKS) - lo_cut;
                nxt_hi = CW'(HALF_TICKS) - (delta - lo_cut);
            end
        end
    end

    gm_level_fsm #(
        .MAX_LEVEL(MAX_LEVEL), .EVENTS_PER_LEVEL(EVENTS_PER_LEVEL), .LW(LW)
    ) u_fsm (
        .clk_ref(clk_ref), .rst_n(rst_n), .start(start), .anomaly(anomaly),
        .alt_done(cyc_end && cur_alt), .state_nx(state_nx), .restart(restart),
        .level(level), .hit(hit), .done(done)
    );

    gm_cycle_sched #(.GLITCH_EVERY(GLITCH_EVERY)) u_sched (
        .clk_ref(clk_ref), .rst_n(rst_n), .restart(restart), .cyc_end(cyc_end),
        .run_next(state_nx == ST_RUN), .alt_next(alt_next), .cur_alt(cur_alt)
    );

    gm_phase_gen #(.HALF_TICKS(HALF_TICKS), .CW(CW)) u_phase (
        .clk_ref(clk_ref), .rst_n(rst_n), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
        .gclk(gclk), .cyc_end(cyc_end)
    );
endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
    parameter int HALF_TICKS = 10,
    parameter int MAX_LEVEL  = 5,
    parameter int LW         = 3
) (
    input logic          clk_ref,
    input logic          rst_n,
    input logic          start,
    input logic          anomaly,
    input logic          gclk,
    input logic [LW-1:0] level,
    input logic          hit,
    input logic          done
);
    int unsigned high_run;

    always_ff @(posedge clk_ref) begin
        if (!rst_n)    high_run <= 0;
        else if (gclk) high_run <= high_run + 1;
        else           high_run <= 0;
    end

    AST_HIGH_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_n)
        high_run <= HALF_TICKS); // R4
    AST_LEVEL_STEP: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !start |=> (level == $past(level)) || (level == $past(level) + LW'(1))); // R5
    AST_DONE_LEVEL: assert property (@(posedge clk_ref) disable iff (!rst_n)
        done |-> (level == LW'(MAX_LEVEL)) && !hit); // R6
    AST_HIT_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (hit && !start) |=> hit && $stable(level)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done && !start) |=> done && $stable(level)); // R10
    AST_RESTART_LVL: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((hit || done) && start) |=> (level == LW'(1)) && !hit && !done); // R9
endmodule

bind glitch_margin_gen gm_checker #(
    .HALF_TICKS(HALF_TICKS), .MAX_LEVEL(MAX_LEVEL), .LW(LW)
) u_chk (
    .clk_ref(clk_ref), .rst_n(rst_n), .start(start), .anomaly(anomaly),
    .gclk(gclk), .level(level), .hit(hit), .done(done)
);

// File: tb/glitch_margin_gen_tb.sv
`timescale 1ns/100ps
module glitch_margin_gen_tb;
    localparam int HALF = 10;
    localparam int STEP = 2;
    localparam int MAXL = 5;
    localparam int NEV  = 4;
    localparam int EVL  = 2;

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       anomaly = 1'b0;
    logic       stretch_mode = 1'b0;
    logic       gclk;
    logic [2:0] level;
    logic       hit;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk_ref = ~clk_ref;

    glitch_margin_gen #(
        .HALF_TICKS(HALF), .STEP_TICKS(STEP), .MAX_LEVEL(MAXL),
        .GLITCH_EVERY(NEV), .EVENTS_PER_LEVEL(EVL)
    ) u_dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .start(start), .anomaly(anomaly),
        .stretch_mode(stretch_mode), .gclk(gclk), .level(level), .hit(hit), .done(done)
    );

    // Behavioural reference: 0 idle, 1 run, 2 hit, 3 done
    int m_st, m_lvl, m_ev, m_cyc, m_t, m_hi, m_lo;
    bit m_ph, m_alt;
    int s_st, s_lvl, s_ev, s_cyc, s_n, s_cut;
    bit s_ce, s_he, s_an;

    always @(posedge clk_ref) begin
        if (!rst_n) begin
            m_st = 0; m_lvl = 0; m_ev = 0; m_cyc = 0;
            m_t = 0; m_ph = 1; m_hi = HALF; m_lo = HALF; m_alt = 0;
        end else begin
            s_ce = (m_ph == 0) && (m_t == m_lo - 1);
            s_he = (m_ph == 1) && (m_t == m_hi - 1);
            s_st = m_st; s_lvl = m_lvl; s_ev = m_ev; s_cyc = m_cyc;
            if (start && m_st != 1) begin
                s_st = 1; s_lvl = 1; s_ev = 0; s_cyc = 0;
            end else if (m_st == 1 && anomaly) begin
                s_st = 2;
            end else if (m_st == 1 && s_ce && m_alt) begin
                s_ev = m_ev + 1;
                if (s_ev == EVL) begin
                    s_ev = 0;
                    if (m_lvl == MAXL) s_st = 3;
                    else s_lvl = m_lvl + 1;
                end
            end
            if (s_ce) begin
                s_n = (m_cyc == NEV - 1) ? 0 : m_cyc + 1;
                s_an = (s_st == 1) && !(start && m_st != 1) && (s_n == NEV - 1);
                if (!(start && m_st != 1)) s_cyc = s_n;
                m_hi = HALF; m_lo = HALF;
                if (s_an) begin
                    if (stretch_mode) m_lo = HALF + STEP * m_lvl;
                    else begin
                        s_cut = (STEP * m_lvl > HALF - 1) ? HALF - 1 : STEP * m_lvl;
                        m_lo = HALF - s_cut;
                        m_hi = HALF - (STEP * m_lvl - s_cut);
                    end
                end
                m_alt = s_an; m_ph = 1; m_t = 0;
            end else if (s_he) begin
                m_ph = 0; m_t = 0;
            end else begin
                m_t = m_t + 1;
            end
            m_st = s_st; m_lvl = s_lvl; m_ev = s_ev; m_cyc = s_cyc;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk_ref) begin
        if (rst_n) begin
            check(cur_req, "gclk", int'(gclk), int'(m_ph));
            check(cur_req, "level", int'(level), m_lvl);
            check(cur_req, "hit", int'(hit), int'(m_st == 2));
            check(cur_req, "done", int'(done), int'(m_st == 3));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic pulse_anomaly();
        anomaly = 1'b1; tick(1); anomaly = 1'b0;
    endtask

    task automatic wait_level(input int lv);
        for (int i = 0; i < 5000 && int'(level) != lv; i++) tick(1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done; i++) tick(1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    int lv_before;

    initial begin
        tick(3);
        // R1: reset values
        check("R1", "gclk", int'(gclk), 1);
        check("R1", "level", int'(level), 0);
        check("R1", "hit", int'(hit), 0);
        check("R1", "done", int'(done), 0);
        rst_n = 1'b1;
        cur_req = "R2"; tick(100);
        cur_req = "R10"; pulse_anomaly(); tick(30);
        check("R10", "hit", int'(hit), 0);
        cur_req = "R3"; tick(7); pulse_start(); tick(2);
        check("R3", "level", int'(level), 1);
        cur_req = "R5"; wait_level(2); tick(5);
        cur_req = "R9"; lv_before = int'(level); pulse_start(); tick(3);
        check("R9", "level", int'(level), lv_before);
        cur_req = "R7"; wait_level(3); tick(40); pulse_anomaly(); tick(1);
        check("R7", "hit", int'(hit), 1);
        check("R7", "level", int'(level), 3);
        tick(200);
        cur_req = "R10"; pulse_anomaly(); tick(20);
        check("R10", "level", int'(level), 3);
        cur_req = "R4"; pulse_start(); tick(1);
        check("R9", "hit", int'(hit), 0);
        wait_done();
        cur_req = "R6"; tick(1);
        check("R6", "done", int'(done), 1);
        check("R6", "level", int'(level), MAXL);
        tick(200);
        pulse_anomaly(); tick(10);
        check("R10", "done", int'(done), 1);
        cur_req = "R8"; stretch_mode = 1'b1; pulse_start(); tick(1);
        check("R9", "done", int'(done), 0);
        wait_level(3); tick(60); pulse_anomaly(); tick(1);
        check("R8", "hit", int'(hit), 1);
        stretch_mode = 1'b0; tick(100);
        finish_run();
    end
endmodule